// File: doc/BRIEF.md
# Serial Clock Glitch Detector

This block watches two serial clocks that arrive from outside the chip, one for receive and one for transmit, and reports any high or low phase that is too short to be a real clock phase. Each raw clock is first brought into the system clock domain through a multi-flop synchronizer. The synchronized level is then timed phase by phase with a small saturating counter. A phase that ends before it has lasted `MIN_PHASE` system clock cycles counts as a glitch. The default of two cycles means that a clean serial clock can run at up to one quarter of the system clock rate.

Each line has its own sticky event bit, which software clears by writing a one to it. A per-line mask bit decides whether a held event drives the interrupt output. A single enable input switches detection on and off. While detection is off, the phase counters stay cleared. After detection is switched on, the first edge seen only starts a measurement and is never judged, so a phase that began before enable cannot be reported falsely.

Top module: `sclk_glitch_mon`

## Requirements
- R1: After reset, `evt_bits` is 0 and `irq` is 0.
- R2: Both clock lines are monitored independently. A receive-clock glitch sets `evt_bits[0]` and a transmit-clock glitch sets `evt_bits[1]`. A glitch on one line never sets the other line's bit.
- R3: After synchronization, a high or low phase lasting fewer than `MIN_PHASE` (default 2) system cycles is a glitch. Phases of `MIN_PHASE` cycles or longer raise no event.
- R4: An event bit stays set until a cycle with `evt_clr_we` = 1 and a 1 in the matching bit of `evt_clr_data`. When `evt_clr_we` = 0 the bits are left unchanged, and a 0 data bit leaves its event bit unchanged.
- R5: `irq` is 1 exactly when some bit i has both `evt_bits[i]` = 1 and `irq_mask[i]` = 1.
- R6: While `det_en` = 0, no event bit is ever set, whatever the clock lines do.
- R7: The phase counters are held cleared while `det_en` = 0. The first edge after `det_en` rises only starts timing and never produces an event.
- R8: If a glitch and a clear of the same bit happen in the same cycle, the bit is set (setting wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sclk | input | 1 | Raw receive serial clock |
| tx_sclk | input | 1 | Raw transmit serial clock |
| det_en | input | 1 | Glitch detection enable |
| irq_mask | input | 2 | Per-event interrupt enables (bit 0 receive, bit 1 transmit) |
| evt_clr_we | input | 1 | Write strobe for clearing event bits |
| evt_clr_data | input | 2 | Write-one-to-clear data for the event bits |
| evt_bits | output | 2 | Sticky glitch events (bit 0 receive, bit 1 transmit) |
| irq | output | 1 | Masked interrupt request |

## Verification
The checker watches every cycle for the following:
- an event bit never appears without a glitch pulse and an enable in the previous cycle;
- a set bit is never lost except through a matching clear write;
- a pulse seen together with a clear still sets its bit;
- `irq` is never raised without both a held event and a mask bit.

Only the bench scenarios can show that the width threshold lies exactly at `MIN_PHASE`. The bench sweeps both lines, both polarities and widths 1 to 4. It also checks that a phase which straddles the rising edge of the enable goes unreported, and that each mask and clear bit acts on its own line alone.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int NUM_LINES = 2;
   localparam int LINE_RX   = 0;
   localparam int LINE_TX   = 1;
   typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/sgd_sync.sv
module sgd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sgd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sgd_phase_chk.sv
module sgd_phase_chk #(
   parameter int   MIN_PHASE = 2,
   parameter logic RST_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lvl,
   output logic glitch
);
   localparam int CNT_W = $clog2(MIN_PHASE + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_PHASE);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   if (MIN_PHASE < 2) begin : g_bad_min
      $error("sgd_phase_chk: MIN_PHASE must be at least 2");
   end

   logic             lvl_q;
   logic             edge_seen;
   logic             timing;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl;
   end

   assign edge_seen = lvl ^ lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         timing <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         timing <= 1'b0;
      end else if (edge_seen) begin
         cnt    <= ONE;
         timing <= 1'b1;
      end else if (cnt < LIMIT) begin
         cnt    <= cnt + ONE;
      end
   end

   assign glitch = en & edge_seen & timing & (cnt < LIMIT);
endmodule

// File: rtl/sgd_event_reg.sv
module sgd_event_reg #(
   parameter int N        = 2,
   parameter bit CLR_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_we,
   input  logic [N-1:0] clr_vec,
   input  logic [N-1:0] mask,
   output logic [N-1:0] evt,
   output logic         irq
);
   logic [N-1:0] clr_eff;
   logic [N-1:0] evt_nxt;

   assign clr_eff = clr_we ? clr_vec : '0;

   if (CLR_WINS) begin : g_clr_first
      assign evt_nxt = (evt | set_vec) & ~clr_eff;
   end else begin : g_set_first
      assign evt_nxt = (evt & ~clr_eff) | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= '0;
      else        evt <= evt_nxt;
   end

   assign irq = |(evt & mask);
endmodule

// File: rtl/sclk_glitch_mon.sv
module sclk_glitch_mon
   import sgd_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter int   MIN_PHASE   = 2,
   parameter logic IDLE_LEVEL  = 1'b0,
   parameter bit   CLR_WINS    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_sclk,
   input  logic                 tx_sclk,
   input  logic                 det_en,
   input  logic [NUM_LINES-1:0] irq_mask,
   input  logic                 evt_clr_we,
   input  logic [NUM_LINES-1:0] evt_clr_data,
   output logic [NUM_LINES-1:0] evt_bits,
   output logic                 irq
);
   line_vec_t raw_vec;
   line_vec_t sync_vec;
   line_vec_t glitch_vec;

   assign raw_vec[LINE_RX] = rx_sclk;
   assign raw_vec[LINE_TX] = tx_sclk;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      sgd_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (IDLE_LEVEL)
      ) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_vec[i]),
         .q     (sync_vec[i])
      );

      sgd_phase_chk #(
         .MIN_PHASE (MIN_PHASE),
         .RST_VAL   (IDLE_LEVEL)
      ) i_chk (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (det_en),
         .lvl    (sync_vec[i]),
         .glitch (glitch_vec[i])
      );
   end

   sgd_event_reg #(
      .N        (NUM_LINES),
      .CLR_WINS (CLR_WINS)
   ) i_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (glitch_vec),
      .clr_we  (evt_clr_we),
      .clr_vec (evt_clr_data),
      .mask    (irq_mask),
      .evt     (evt_bits),
      .irq     (irq)
   );
endmodule

// File: rtl/sgd_check.sv
module sgd_check #(
   parameter int N        = 2,
   parameter bit CLR_WINS = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         det_en,
   input logic [N-1:0] glitch_vec,
   input logic         clr_we,
   input logic [N-1:0] clr_data,
   input logic [N-1:0] irq_mask,
   input logic [N-1:0] evt_bits,
   input logic         irq
);
   // R6: a newly set event bit needs detection enabled one cycle earlier
   a_r6_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_bits & ~$past(evt_bits))) |-> $past(det_en));

   // R3: every newly set bit comes from a glitch pulse on its own line
   a_r3_event_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_bits & ~$past(evt_bits) & ~$past(glitch_vec)) == '0));

   // R7: a glitch pulse requires a cycle of enable before it
   a_r7_pulse_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (|glitch_vec) |-> $past(det_en));

   // R4: a set bit is lost only through a matching clear write
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_bits) & ~($past(clr_we) ? $past(clr_data) : '0) & ~evt_bits) == '0));

   // R5: the interrupt needs a held event and some mask bit
   a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((|evt_bits) && (|irq_mask)));

   if (!CLR_WINS) begin : g_set_wins
      // R8: a pulse sets its bit even when a clear lands in the same cycle
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (|glitch_vec) |=> ((evt_bits & $past(glitch_vec)) == $past(glitch_vec)));
   end
endmodule

bind sclk_glitch_mon sgd_check #(
   .N        (sgd_pkg::NUM_LINES),
   .CLR_WINS (CLR_WINS)
) i_sgd_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .det_en     (det_en),
   .glitch_vec (glitch_vec),
   .clr_we     (evt_clr_we),
   .clr_data   (evt_clr_data),
   .irq_mask   (irq_mask),
   .evt_bits   (evt_bits),
   .irq        (irq)
);

// File: tb/test_sclk_glitch_mon.sv
module test_sclk_glitch_mon;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_sclk = 1'b0;
   logic       tx_sclk = 1'b0;
   logic       det_en = 1'b0;
   logic [1:0] irq_mask = 2'b00;
   logic       evt_clr_we = 1'b0;
   logic [1:0] evt_clr_data = 2'b00;
   logic [1:0] evt_bits;
   logic       irq;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sclk_glitch_mon i_sclk_glitch_mon (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_sclk      (rx_sclk),
      .tx_sclk      (tx_sclk),
      .det_en       (det_en),
      .irq_mask     (irq_mask),
      .evt_clr_we   (evt_clr_we),
      .evt_clr_data (evt_clr_data),
      .evt_bits     (evt_bits),
      .irq          (irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_line(input int line, input logic v);
      if (line == 0) rx_sclk = v;
      else           tx_sclk = v;
   endtask

   task automatic clear_bits(input logic [1:0] which);
      evt_clr_we = 1'b1;
      evt_clr_data = which;
      tick(1);
      evt_clr_we = 1'b0;
      evt_clr_data = 2'b00;
   endtask

   // long legal phase, short phase of width w, long legal phase
   task automatic pulse(input int line, input logic base, input int w);
      set_line(line, ~base);
      tick(4);
      set_line(line, base);
      tick(w);
      set_line(line, ~base);
      tick(4);
      set_line(line, base);
      tick(8);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=0", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seen;
      tick(3);
      chk("R1 evt_bits", int'(evt_bits), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 evt_bits after release", int'(evt_bits), 0);

      // R2 R3 R5: sweep line, polarity and short-phase width
      det_en = 1'b1;
      irq_mask = 2'b11;
      for (int line = 0; line < 2; line++) begin
         for (int b = 0; b < 2; b++) begin
            for (int w = 1; w <= 4; w++) begin
               set_line(line, logic'(b));
               tick(8);
               clear_bits(2'b11);
               tick(2);
               pulse(line, logic'(b), w);
               chk($sformatf("R3 R2 line=%0d base=%0d w=%0d", line, b, w),
                   int'(evt_bits), (w < 2) ? (1 << line) : 0);
               chk($sformatf("R5 irq line=%0d w=%0d", line, w),
                   int'(irq), (w < 2) ? 1 : 0);
            end
         end
         set_line(line, 1'b0);
         tick(8);
      end

      // R6: disabled, short pulses on both lines leave no event
      clear_bits(2'b11);
      det_en = 1'b0;
      tick(2);
      pulse(0, 1'b0, 1);
      pulse(1, 1'b1, 1);
      tx_sclk = 1'b0;
      tick(8);
      chk("R6 evt_bits while disabled", int'(evt_bits), 0);
      chk("R6 irq while disabled", int'(irq), 0);

      // R7: phase begun before enable is not judged at its end
      rx_sclk = 1'b1;
      tick(10);
      rx_sclk = 1'b0;
      tick(1);
      det_en = 1'b1;
      tick(10);
      chk("R7 no false glitch at enable", int'(evt_bits), 0);

      // R2 R5 R4: both events, then masks and clears
      rx_sclk = 1'b1; tx_sclk = 1'b1;
      tick(4);
      rx_sclk = 1'b0; tx_sclk = 1'b0;
      tick(1);
      rx_sclk = 1'b1; tx_sclk = 1'b1;
      tick(4);
      rx_sclk = 1'b0; tx_sclk = 1'b0;
      tick(8);
      chk("R2 both events", int'(evt_bits), 3);
      for (int m = 0; m < 4; m++) begin
         irq_mask = 2'(m);
         tick(1);
         chk($sformatf("R5 mask=%0d", m), int'(irq), (m != 0) ? 1 : 0);
      end
      irq_mask = 2'b01;
      evt_clr_data = 2'b11;
      tick(2);
      evt_clr_data = 2'b00;
      chk("R4 data without strobe", int'(evt_bits), 3);
      clear_bits(2'b01);
      chk("R4 clear bit0 only", int'(evt_bits), 2);
      chk("R5 masked remaining", int'(irq), 0);
      clear_bits(2'b10);
      chk("R4 clear bit1", int'(evt_bits), 0);

      // R8: clear held high during a glitch, bit still shows for one cycle
      evt_clr_we = 1'b1;
      evt_clr_data = 2'b01;
      rx_sclk = 1'b1;
      tick(4);
      rx_sclk = 1'b0;
      tick(1);
      rx_sclk = 1'b1;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         tick(1);
         if (evt_bits[0]) seen++;
      end
      evt_clr_we = 1'b0;
      evt_clr_data = 2'b00;
      chk("R8 set wins over clear", seen, 1);
      rx_sclk = 1'b0;
      tick(8);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule